// File: doc/BRIEF.md
# Buffered Pulse-Width and Frequency Modulation Channel

This block is one timer channel that produces a waveform whose high time and period can both be set by software. A free-running up-counter restarts whenever it reaches a period compare value, so the output frequency comes from a compare match rather than from counter overflow. A second compare value marks where the active phase of each cycle ends.

Software writes new compare values into staging registers. A control bit decides when those values reach the active compare registers. They can move across at the write itself, or they can wait until the counter next restarts, so that every output cycle uses one consistent pair of values.

The channel also has an output polarity bit and a status flag whose source can be selected. The flag is cleared by writing 1 to it. Two force strobes drive the output as if either comparator had matched. A simple synchronous write/read port with a registered read path gives access to all of this.

Top module: `pwmfm_channel`

## Requirements
- R1: After synchronous reset, `pwm_out`, `flag_out` and `bus_rdata` are 0, and every register reads 0. This includes the control word, so the channel starts in a non-running mode with polarity 0.
- R2: In a running mode, the counter steps 0,1,...,P and then restarts, where P is the active period value. The output holds its active level from the cycle in which the counter shows 0 through the cycle in which it equals the active duty value D. That is D+1 cycles in every P+1. If D > P, the output is active all the time.
- R3: When control bit 0 is 0 (immediate update), a write to staging register 2 (duty) or 3 (period) loads the matching active register at the same clock edge.
- R4: When control bit 0 is 1 (buffered update), the active registers take the staging values only at the edge where the counter restarts, which is a period match or a force-B. Until then, reads of address 6 (active duty) and 7 (active period) return the old values.
- R5: When control bit 1 is 0, the flag is set only by a period match. When control bit 1 is 1, a duty match also sets the flag.
- R6: Writing to address 4 with data bit 0 at 1 clears the flag. If a set event falls in the same cycle as the clear, the flag stays set.
- R7: A write to address 1 with bit 0 set (force-A) drives the output inactive. With bit 1 set (force-B), the write drives the output active and restarts the counter at 0. Neither strobe sets the flag. If both bits are set, force-A wins.
- R8: When a duty match and a period match happen in the same cycle, the duty match wins. With D = P the output therefore stays at the inactive level (0% duty).
- R9: If the counter is above the active period value, the channel treats that cycle as a period match. The counter is 0 on the next cycle, and the flag is set as for a period match.
- R10: If control bits 6..2 are anything other than 00110, the counter is held at 0 and the output sits at the inactive level. No flag is set, and force strobes have no effect.
- R11: The inactive output level equals control bit 7 (polarity), and the active level is its inverse.
- R12: Register map (read data is registered one cycle after the address):
  - address 0: control word, with bits 6..0 the mode and bit 7 the polarity. The running modes are 0x18, 0x19, 0x1A and 0x1B.
  - address 1: force strobes, which read back as 0.
  - addresses 2 and 3: staging duty and staging period.
  - address 4: flag in bit 0.
  - address 5: counter.
  - addresses 6 and 7: active duty and active period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register address for both writes and reads |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_wdata | input | W | Write data |
| bus_rdata | output | W | Registered read data for the address presented one cycle earlier |
| pwm_out | output | 1 | Registered modulated output |
| flag_out | output | 1 | Registered status flag |

## Verification
If the counter or an active compare register holds a wrong value, `pwm_out` shows it as a wrong edge position within one output period. A wrong value also shows within one clock when read back at address 5, 6 or 7. Because the update mode is buffered, a wrong transfer moment appears as an active value that changes early or late with respect to the next counter restart. A fault in the flag source or the set/clear priority reaches `flag_out` on the clock after the match. Comparing every output on every clock against a behavioural model therefore catches a divergence in the cycle where it first becomes visible.

// File: rtl/pwmfm_pkg.sv
package pwmfm_pkg;

  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
  localparam logic [ADDR_W-1:0] A_FORCE = 3'd1;
  localparam logic [ADDR_W-1:0] A_STG_D = 3'd2;
  localparam logic [ADDR_W-1:0] A_STG_P = 3'd3;
  localparam logic [ADDR_W-1:0] A_STAT  = 3'd4;
  localparam logic [ADDR_W-1:0] A_CNT   = 3'd5;
  localparam logic [ADDR_W-1:0] A_ACT_D = 3'd6;
  localparam logic [ADDR_W-1:0] A_ACT_P = 3'd7;

  // upper five mode bits shared by all running modes
  localparam logic [4:0] MODE_FAMILY = 5'b00110;

  typedef struct packed {
    logic       pol;
    logic [6:0] mode;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  // number of compare slots (duty, period)
  localparam int NSLOT = 2;

endpackage

// File: rtl/pwmfm_regs.sv
module pwmfm_regs
  import pwmfm_pkg::*;
#(
  parameter int W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [W-1:0]      bus_wdata,
  input  logic [W-1:0]      cnt,
  input  logic [W-1:0]      act_d,
  input  logic [W-1:0]      act_p,
  input  logic              flag_set,
  output ctrl_t             ctrl,
  output logic [W-1:0]      stg_d,
  output logic [W-1:0]      stg_p,
  output logic              wr_stg_d,
  output logic              wr_stg_p,
  output logic              frc_a,
  output logic              frc_b,
  output logic              flag_q,
  output logic [W-1:0]      rdata
);

  logic wr_ctrl, wr_force, wr_stat;

  always_comb begin
    wr_ctrl  = bus_wr && (bus_addr == A_CTRL);
    wr_force = bus_wr && (bus_addr == A_FORCE);
    wr_stg_d = bus_wr && (bus_addr == A_STG_D);
    wr_stg_p = bus_wr && (bus_addr == A_STG_P);
    wr_stat  = bus_wr && (bus_addr == A_STAT);
    frc_a    = wr_force && bus_wdata[0];
    frc_b    = wr_force && bus_wdata[1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl  <= '0;
      stg_d <= '0;
      stg_p <= '0;
    end else begin
      if (wr_ctrl)  ctrl  <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
      if (wr_stg_d) stg_d <= bus_wdata;
      if (wr_stg_p) stg_p <= bus_wdata;
    end
  end

  // set has priority over a clear in the same cycle
  always_ff @(posedge clk) begin
    if (rst)                         flag_q <= 1'b0;
    else if (flag_set)               flag_q <= 1'b1;
    else if (wr_stat && bus_wdata[0]) flag_q <= 1'b0;
  end

  logic [W-1:0] rd_mux;

  always_comb begin
    unique case (bus_addr)
      A_CTRL:  rd_mux = W'(ctrl);
      A_FORCE: rd_mux = '0;
      A_STG_D: rd_mux = stg_d;
      A_STG_P: rd_mux = stg_p;
      A_STAT:  rd_mux = W'(flag_q);
      A_CNT:   rd_mux = cnt;
      A_ACT_D: rd_mux = act_d;
      default: rd_mux = act_p;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_mux;
  end

endmodule

// File: rtl/pwmfm_cmp_slot.sv
module pwmfm_cmp_slot #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         imm,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] stage,
  input  logic         restart,
  output logic [W-1:0] act
);

  always_ff @(posedge clk) begin
    if (rst) begin
      act <= '0;
    end else if (imm) begin
      act <= wr ? wdata : stage;
    end else if (restart) begin
      act <= stage;
    end
  end

endmodule

// File: rtl/pwmfm_timebase.sv
module pwmfm_timebase #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic         frc_b,
  input  logic [W-1:0] act_d,
  input  logic [W-1:0] act_p,
  output logic [W-1:0] cnt,
  output logic         hit_d,
  output logic         hit_p,
  output logic         restart
);

  always_comb begin
    hit_d   = run && (cnt == act_d);
    // a count above the period also counts as a period match
    hit_p   = run && (cnt >= act_p);
    restart = run && (hit_p || frc_b);
  end

  always_ff @(posedge clk) begin
    if (rst || !run || restart) cnt <= '0;
    else                        cnt <= cnt + W'(1);
  end

endmodule

// File: rtl/pwmfm_outgen.sv
module pwmfm_outgen (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic pol,
  input  logic ev_off,
  input  logic ev_on,
  output logic pwm
);

  always_ff @(posedge clk) begin
    if (rst)                pwm <= 1'b0;
    else if (!run || ev_off) pwm <= pol;
    else if (ev_on)         pwm <= ~pol;
  end

endmodule

// File: rtl/pwmfm_channel.sv
module pwmfm_channel
  import pwmfm_pkg::*;
#(
  parameter int W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [W-1:0]      bus_wdata,
  output logic [W-1:0]      bus_rdata,
  output logic              pwm_out,
  output logic              flag_out
);

  ctrl_t        ctrl;
  logic [W-1:0] stg_d, stg_p, act_d, act_p, cnt_q;
  logic         wr_stg_d, wr_stg_p, frc_a, frc_b;
  logic         hit_d, hit_p, restart, flag_set;
  logic         mode_ok, imm;

  logic [W-1:0] slot_stage [NSLOT];
  logic [W-1:0] slot_act   [NSLOT];
  logic         slot_wr    [NSLOT];

  always_comb begin
    mode_ok  = (ctrl.mode[6:2] == MODE_FAMILY);
    imm      = ~ctrl.mode[0];
    flag_set = hit_p || (ctrl.mode[1] && hit_d);
    slot_stage[0] = stg_d;
    slot_stage[1] = stg_p;
    slot_wr[0]    = wr_stg_d;
    slot_wr[1]    = wr_stg_p;
    act_d = slot_act[0];
    act_p = slot_act[1];
  end

  pwmfm_regs #(.W(W)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .bus_addr (bus_addr),
    .bus_wr   (bus_wr),
    .bus_wdata(bus_wdata),
    .cnt      (cnt_q),
    .act_d    (act_d),
    .act_p    (act_p),
    .flag_set (flag_set),
    .ctrl     (ctrl),
    .stg_d    (stg_d),
    .stg_p    (stg_p),
    .wr_stg_d (wr_stg_d),
    .wr_stg_p (wr_stg_p),
    .frc_a    (frc_a),
    .frc_b    (frc_b),
    .flag_q   (flag_out),
    .rdata    (bus_rdata)
  );

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    pwmfm_cmp_slot #(.W(W)) u_slot (
      .clk    (clk),
      .rst    (rst),
      .imm    (imm),
      .wr     (slot_wr[g]),
      .wdata  (bus_wdata),
      .stage  (slot_stage[g]),
      .restart(restart),
      .act    (slot_act[g])
    );
  end

  pwmfm_timebase #(.W(W)) u_tb (
    .clk    (clk),
    .rst    (rst),
    .run    (mode_ok),
    .frc_b  (frc_b),
    .act_d  (act_d),
    .act_p  (act_p),
    .cnt    (cnt_q),
    .hit_d  (hit_d),
    .hit_p  (hit_p),
    .restart(restart)
  );

  pwmfm_outgen u_out (
    .clk   (clk),
    .rst   (rst),
    .run   (mode_ok),
    .pol   (ctrl.pol),
    .ev_off(frc_a || hit_d),
    .ev_on (frc_b || hit_p),
    .pwm   (pwm_out)
  );

endmodule

// File: rtl/pwmfm_channel_chk.sv
module pwmfm_channel_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic [2:0]   bus_addr,
  input logic         bus_wr,
  input logic [W-1:0] bus_wdata,
  input logic         pwm_out,
  input logic         flag_out,
  input logic [W-1:0] cnt_q,
  input logic [W-1:0] act_d,
  input logic [W-1:0] act_p,
  input logic         mode_ok,
  input logic         pol
);

  logic wr_frc_b, wr_frc_any, wr_clr;

  always_comb begin
    wr_frc_b   = bus_wr && bus_addr == 3'd1 && bus_wdata[1];
    wr_frc_any = bus_wr && bus_addr == 3'd1 && (bus_wdata[1:0] != 2'b00);
    wr_clr     = bus_wr && bus_addr == 3'd4 && bus_wdata[0];
  end

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
    mode_ok && cnt_q < act_p && !wr_frc_b |=> cnt_q == $past(cnt_q) + W'(1)); // R2

  AST_OVERRUN_WRAP: assert property (@(posedge clk) disable iff (rst)
    mode_ok && cnt_q > act_p |=> cnt_q == '0 && flag_out); // R9

  AST_ZERO_DUTY: assert property (@(posedge clk) disable iff (rst)
    mode_ok && act_d == act_p && cnt_q == act_d |=> pwm_out == $past(pol)); // R8

  AST_FORCE_NO_FLAG: assert property (@(posedge clk) disable iff (rst)
    wr_frc_any && !flag_out && cnt_q != act_d && cnt_q < act_p |=> !flag_out); // R7

  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    mode_ok && cnt_q >= act_p && wr_clr |=> flag_out); // R6

  AST_IDLE_MODE: assert property (@(posedge clk) disable iff (rst)
    !mode_ok |=> cnt_q == '0 && pwm_out == $past(pol)); // R10

endmodule

bind pwmfm_channel pwmfm_channel_chk #(.W(W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .bus_addr (bus_addr),
  .bus_wr   (bus_wr),
  .bus_wdata(bus_wdata),
  .pwm_out  (pwm_out),
  .flag_out (flag_out),
  .cnt_q    (cnt_q),
  .act_d    (act_d),
  .act_p    (act_p),
  .mode_ok  (mode_ok),
  .pol      (ctrl.pol)
);

// File: tb/pwmfm_channel_tb.sv
module pwmfm_channel_tb_top;

  localparam int W = 16;
  localparam int MASK = 16'hFFFF;
  localparam int WATCHDOG = 200000;

  logic         clk = 1'b0;
  logic         rst;
  logic [2:0]   bus_addr;
  logic         bus_wr;
  logic [W-1:0] bus_wdata;
  logic [W-1:0] bus_rdata;
  logic         pwm_out;
  logic         flag_out;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  int ones = 0;
  bit done = 0;

  // reference model state
  int m_mode, m_pol, m_sd, m_sp, m_ad, m_ap, m_cnt, m_out, m_flag, m_rd;

  always #10 clk = ~clk;

  pwmfm_channel #(.W(W)) dut_i (
    .clk      (clk),
    .rst      (rst),
    .bus_addr (bus_addr),
    .bus_wr   (bus_wr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .pwm_out  (pwm_out),
    .flag_out (flag_out)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int model_read(input int a);
    case (a)
      0: return (m_pol << 7) | m_mode;
      1: return 0;
      2: return m_sd;
      3: return m_sp;
      4: return m_flag;
      5: return m_cnt;
      6: return m_ad;
      default: return m_ap;
    endcase
  endfunction

  task automatic model_reset();
    m_mode = 0; m_pol = 0; m_sd = 0; m_sp = 0; m_ad = 0; m_ap = 0;
    m_cnt = 0; m_out = 0; m_flag = 0; m_rd = 0;
  endtask

  // one clock: drive, advance model, wait for edge, compare away from edge
  task automatic tick(input int a, input bit w, input int d);
    bit run, imm, fa, fb, clr, ha, hp, wrap, setf;
    int n_cnt, n_out, n_flag, n_ad, n_ap;
    bus_addr  = 3'(a);
    bus_wr    = w;
    bus_wdata = W'(d);
    run  = ((m_mode >> 2) == 6);
    imm  = (m_mode & 1) == 0;
    fa   = run && w && a == 1 && d[0];
    fb   = run && w && a == 1 && d[1];
    clr  = w && a == 4 && d[0];
    ha   = run && m_cnt == m_ad;
    hp   = run && m_cnt >= m_ap;
    wrap = run && (hp || fb);
    setf = hp || (((m_mode >> 1) & 1) == 1 && ha);
    m_rd = model_read(a);
    n_cnt  = (!run || wrap) ? 0 : ((m_cnt + 1) & MASK);
    n_out  = !run ? m_pol : (fa || ha) ? m_pol : (fb || hp) ? 1 - m_pol : m_out;
    n_flag = setf ? 1 : clr ? 0 : m_flag;
    n_ad   = imm ? ((w && a == 2) ? d : m_sd) : (wrap ? m_sd : m_ad);
    n_ap   = imm ? ((w && a == 3) ? d : m_sp) : (wrap ? m_sp : m_ap);
    if (w && a == 2) m_sd = d & MASK;
    if (w && a == 3) m_sp = d & MASK;
    if (w && a == 0) begin m_mode = d & 127; m_pol = (d >> 7) & 1; end
    m_cnt = n_cnt; m_out = n_out; m_flag = n_flag;
    m_ad = n_ad & MASK; m_ap = n_ap & MASK;
    @(posedge clk);
    @(negedge clk);
    cycles++;
    ones += int'(pwm_out);
    check("R2", "pwm_out vs model", int'(pwm_out), m_out);
    check("R5", "flag_out vs model", int'(flag_out), m_flag);
    check("R12", "bus_rdata vs model", int'(bus_rdata), m_rd);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick(5, 1'b0, 0);
  endtask

  task automatic measure(input int n, output int hi);
    ones = 0;
    idle(n);
    hi = ones;
  endtask

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", WATCHDOG, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : stim
    int hi;
    rst = 1'b1; bus_addr = '0; bus_wr = 1'b0; bus_wdata = '0;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    check("R1", "pwm_out after reset", int'(pwm_out), 0);
    check("R1", "flag_out after reset", int'(flag_out), 0);
    check("R1", "rdata after reset", int'(bus_rdata), 0);
    tick(0, 1'b0, 0);
    tick(5, 1'b0, 0);
    check("R1", "ctrl reads zero", int'(bus_rdata), 0);

    // R2: duty 3 of 6
    tick(0, 1'b1, 'h18);
    tick(2, 1'b1, 2);
    tick(3, 1'b1, 5);
    idle(20);
    measure(60, hi);
    check("R2", "active cycles D=2 P=5", hi, 30);
    tick(2, 1'b1, 1);
    idle(20);
    measure(60, hi);
    check("R2", "active cycles D=1 P=5", hi, 20);

    // R11: inverted polarity
    tick(0, 1'b1, 'h98);
    idle(20);
    measure(60, hi);
    check("R11", "high cycles with polarity 1", hi, 40);
    tick(0, 1'b1, 'h18);

    // R8: zero duty, then R2 full duty
    tick(2, 1'b1, 5);
    idle(20);
    measure(60, hi);
    check("R8", "high cycles with D=P", hi, 0);
    tick(2, 1'b1, 7);
    idle(20);
    measure(60, hi);
    check("R2", "high cycles with D>P", hi, 60);

    // R3: immediate update
    tick(2, 1'b1, 4);
    tick(6, 1'b0, 0);
    check("R3", "active duty right after write", int'(bus_rdata), 4);

    // R4: buffered update
    tick(0, 1'b1, 'h19);
    tick(2, 1'b1, 1);
    tick(6, 1'b0, 0);
    check("R4", "active duty held before restart", int'(bus_rdata), 4);
    idle(8);
    tick(6, 1'b0, 0);
    check("R4", "active duty after restart", int'(bus_rdata), 1);

    // R5 / R6: flag source and priority
    tick(0, 1'b1, 'h18);
    tick(3, 1'b1, 200);
    tick(2, 1'b1, 0);
    tick(1, 1'b1, 2);
    tick(4, 1'b1, 1);
    check("R5", "duty match ignored by flag in mode 0x18", int'(flag_out), 0);
    tick(0, 1'b1, 'h1A);
    tick(1, 1'b1, 2);
    tick(4, 1'b1, 1);
    check("R6", "set beats clear on duty match in mode 0x1A", int'(flag_out), 1);
    idle(2);
    tick(4, 1'b1, 1);
    check("R6", "clear by writing 1", int'(flag_out), 0);

    // R7: forces
    tick(0, 1'b1, 'h18);
    tick(2, 1'b1, 50);
    tick(1, 1'b1, 2);
    check("R7", "force-B drives active", int'(pwm_out), 1);
    check("R7", "force-B leaves flag clear", int'(flag_out), 0);
    tick(1, 1'b1, 1);
    check("R7", "force-A drives inactive", int'(pwm_out), 0);
    check("R7", "force-A leaves flag clear", int'(flag_out), 0);
    tick(1, 1'b1, 3);
    check("R7", "both forces: A wins", int'(pwm_out), 0);

    // R9: period lowered below count
    idle(80);
    tick(3, 1'b1, 10);
    tick(5, 1'b0, 0);
    tick(5, 1'b0, 0);
    check("R9", "counter restarted after overrun", int'(bus_rdata), 0);
    check("R9", "overrun sets flag", int'(flag_out), 1);

    // R10: non-running mode
    tick(0, 1'b1, 'h80);
    idle(2);
    check("R10", "output at polarity in idle mode", int'(pwm_out), 1);
    tick(1, 1'b1, 2);
    tick(5, 1'b0, 0);
    check("R10", "force-B ignored in idle mode", int'(pwm_out), 1);
    tick(5, 1'b0, 0);
    check("R10", "counter held at zero", int'(bus_rdata), 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule